// File: doc/BRIEF.md
# Timer Gating for Low-Power Stop and Debug Freeze

This block holds two timers, a service-keyed watchdog and a periodic interrupt timer, together with the logic that decides which timers and which bus-health monitors keep running. The watchdog and the periodic timer react differently to three conditions. An ordinary stop leaves the watchdog counting. A low-power stop holds the watchdog and turns off all three monitors, but the periodic timer keeps running so that it can wake the part. A debug freeze stops each timer only if that timer's own freeze bit is set.

A low-power stop is a registered state. It is entered on the clock edge after the request is seen with the halt input low. It is left on the edge after the request drops. While the halt input is high, entry waits. The periodic timer reloads its period on every expiry and holds its interrupt request until it is acknowledged. The request wakes the part only when its level is above the current CPU mask.

Top module: `tmr_gate_top`

## Requirements
- R1: While reset is low, wd_rst_pulse, wd_irq, pit_irq and wake_req are 0 and pit_irq_lvl is 0. Out of reset the three monitor enables are 1.
- R2: With wd_en high and nothing holding it, the watchdog expires on the (WD_LIMIT+1)-th clock edge after it starts or after a service clear. With wd_irq_mode=0 an expiry gives a one-cycle wd_rst_pulse. With wd_irq_mode=1 it sets wd_irq, which stays high until the next completed service.
- R3: A service is a svc_wr of 0x55 followed on the very next write by a svc_wr of 0xAA. The completed service zeroes the watchdog count. Any other order, or any other value between the two writes, leaves the count unchanged.
- R4: With the default parameters, stop_in has no effect on watchdog timing.
- R5: The low-power state is set on the edge after lpstop_req is sampled high with halt_in low, and cleared on the edge after lpstop_req is sampled low. The watchdog counts on no edge at which the state is set. It resumes on the first edge after the state clears.
- R6: While not in the low-power state, a high halt_in keeps the block out of it. Once in the state, halt_in has no effect.
- R7: busmon_en, dblflt_en and spur_en are 0 exactly while in the low-power state. freeze_in does not change them.
- R8: When freeze_in is high, cfg_frz_wd=1 stops the watchdog and cfg_frz_pit=1 stops the periodic timer. Each bit acts alone. With its bit clear, freeze_in does not affect that timer.
- R9: From a stopped count, the periodic timer with period P raises pit_irq on the (P+1)-th edge and then every P edges. pit_irq stays high until pit_ack. pit_irq_lvl equals pit_level while pit_irq is high and is 0 otherwise.
- R10: pit_period=0 stops the periodic timer, and no new request is raised.
- R11: The periodic timer keeps running in the low-power state. wake_req is high exactly when the block is in that state, pit_irq is high, and pit_level is greater than irq_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lpstop_req | input | 1 | Request for low-power stop, held while wanted |
| stop_in | input | 1 | Ordinary stop indication |
| halt_in | input | 1 | Holds off entry into low-power stop |
| freeze_in | input | 1 | Debug freeze |
| cfg_frz_wd | input | 1 | Freeze stops the watchdog |
| cfg_frz_pit | input | 1 | Freeze stops the periodic timer |
| wd_en | input | 1 | Watchdog enable; low clears its count |
| wd_irq_mode | input | 1 | 0: expiry gives a reset pulse, 1: expiry gives an interrupt |
| svc_wr | input | 1 | Service write strobe |
| svc_data | input | 8 | Service write value |
| pit_period | input | PIT_W | Periodic timer period; 0 stops the timer |
| pit_level | input | LVL_W | Periodic timer interrupt level |
| pit_ack | input | 1 | Acknowledge of the periodic interrupt |
| irq_mask | input | LVL_W | Current CPU interrupt mask level |
| wd_rst_pulse | output | 1 | Watchdog reset pulse |
| wd_irq | output | 1 | Watchdog interrupt |
| pit_irq | output | 1 | Periodic interrupt request |
| pit_irq_lvl | output | LVL_W | Level of the pending periodic request |
| wake_req | output | 1 | Wake from low-power stop |
| busmon_en | output | 1 | Bus monitor enable |
| dblflt_en | output | 1 | Double bus fault monitor enable |
| spur_en | output | 1 | Spurious interrupt monitor enable |

## Verification
The bench times the watchdog across a low-power stop and across a freeze. A design that counted the entry edge wrongly, or the resume edge wrongly, would expire one cycle early or one cycle late. It feeds the service keys in the wrong order and with a stray write between them; a design that accepted those would push the expiry out. It raises the halt input before entry and again after entry: a design that ignored the halt would drop the monitors too early, and one that let the halt end the stop would bring them back. It also checks the mask comparison for the wake in both directions, and checks that a zero period and a freeze with the timer's bit set both keep the periodic request from being raised.

// File: rtl/tmr_gate_pkg.sv
package tmr_gate_pkg;

   typedef enum logic {
      WD_TO_RESET = 1'b0,
      WD_TO_IRQ   = 1'b1
   } wd_mode_e;

   typedef struct packed {
      logic lp_active;
      logic wd_run;
      logic pit_hold;
   } gate_s;

endpackage

// File: rtl/tmr_gate_ctl.sv
module tmr_gate_ctl
   import tmr_gate_pkg::*;
#(
   parameter bit STOP_HOLDS_WD = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lpstop_req,
   input  logic  stop_in,
   input  logic  halt_in,
   input  logic  freeze_in,
   input  logic  cfg_frz_wd,
   input  logic  cfg_frz_pit,
   input  logic  wd_en,
   output gate_s gate,
   output logic  busmon_en,
   output logic  dblflt_en,
   output logic  spur_en
);

   logic lp_q;
   logic lp_d;

   // Halt only matters before the state is entered.
   assign lp_d = lpstop_req && (lp_q || !halt_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lp_q <= 1'b0;
      else        lp_q <= lp_d;
   end

   logic stop_hold;
   assign stop_hold = STOP_HOLDS_WD && stop_in;

   always_comb begin
      gate.lp_active = lp_q;
      gate.wd_run    = wd_en && !lp_q && !(freeze_in && cfg_frz_wd) && !stop_hold;
      gate.pit_hold  = freeze_in && cfg_frz_pit;
   end

   assign busmon_en = !lp_q;
   assign dblflt_en = !lp_q;
   assign spur_en   = !lp_q;

endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog
   import tmr_gate_pkg::*;
#(
   parameter int unsigned WD_W     = 16,
   parameter int unsigned WD_LIMIT = 40000,
   parameter int unsigned KEY_W    = 8,
   parameter logic [7:0]  KEY_A    = 8'h55,
   parameter logic [7:0]  KEY_B    = 8'hAA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             run,
   input  logic             mode,
   input  logic             svc_wr,
   input  logic [KEY_W-1:0] svc_data,
   output logic             rst_pulse,
   output logic             irq
);

   localparam logic [WD_W-1:0]  TERM  = WD_W'(WD_LIMIT);
   localparam logic [KEY_W-1:0] K_A   = KEY_W'(KEY_A);
   localparam logic [KEY_W-1:0] K_B   = KEY_W'(KEY_B);

   initial begin : elab_chk
      assert (WD_LIMIT > 0 && WD_LIMIT < (64'd1 << WD_W))
         else $error("tmr_wdog: WD_LIMIT does not fit WD_W");
      assert (K_A != K_B)
         else $error("tmr_wdog: service keys must differ");
   end

   logic [WD_W-1:0] cnt_q;
   logic            armed_q;
   logic            key_a_hit;
   logic            svc_done;
   logic            expire;
   wd_mode_e        mode_e;

   assign mode_e    = wd_mode_e'(mode);
   assign key_a_hit = svc_wr && (svc_data == K_A);
   assign svc_done  = svc_wr && armed_q && (svc_data == K_B);
   assign expire    = run && (cnt_q == TERM) && !svc_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         armed_q   <= 1'b0;
         rst_pulse <= 1'b0;
         irq       <= 1'b0;
      end else begin
         if (svc_wr) armed_q <= key_a_hit;

         if (!en || svc_done)  cnt_q <= '0;
         else if (expire)      cnt_q <= '0;
         else if (run)         cnt_q <= cnt_q + WD_W'(1);

         rst_pulse <= expire && (mode_e == WD_TO_RESET);

         if (expire && mode_e == WD_TO_IRQ) irq <= 1'b1;
         else if (svc_done)                 irq <= 1'b0;
      end
   end

endmodule

// File: rtl/tmr_pit.sv
module tmr_pit #(
   parameter int unsigned PIT_W = 8,
   parameter int unsigned LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic [PIT_W-1:0] period,
   input  logic [LVL_W-1:0] level,
   input  logic             ack,
   output logic             irq,
   output logic [LVL_W-1:0] irq_lvl
);

   initial begin : elab_chk
      assert (PIT_W >= 2) else $error("tmr_pit: PIT_W too small");
      assert (LVL_W >= 1) else $error("tmr_pit: LVL_W too small");
   end

   localparam logic [PIT_W-1:0] ONE = PIT_W'(1);

   logic [PIT_W-1:0] cnt_q;
   logic             run;
   logic             fire;

   assign run  = (period != '0) && !hold;
   assign fire = run && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         irq   <= 1'b0;
      end else begin
         if (period == '0)                       cnt_q <= '0;
         else if (run) begin
            if (cnt_q == '0 || cnt_q == ONE)     cnt_q <= period;
            else                                 cnt_q <= cnt_q - ONE;
         end

         if (fire)     irq <= 1'b1;
         else if (ack) irq <= 1'b0;
      end
   end

   assign irq_lvl = irq ? level : '0;

endmodule

// File: rtl/tmr_gate_top.sv
module tmr_gate_top
   import tmr_gate_pkg::*;
#(
   parameter int unsigned WD_W          = 16,
   parameter int unsigned WD_LIMIT      = 40000,
   parameter int unsigned PIT_W         = 8,
   parameter int unsigned LVL_W         = 3,
   parameter bit          SYNC_WAKE     = 1'b0,
   parameter bit          STOP_HOLDS_WD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lpstop_req,
   input  logic             stop_in,
   input  logic             halt_in,
   input  logic             freeze_in,
   input  logic             cfg_frz_wd,
   input  logic             cfg_frz_pit,
   input  logic             wd_en,
   input  logic             wd_irq_mode,
   input  logic             svc_wr,
   input  logic [7:0]       svc_data,
   input  logic [PIT_W-1:0] pit_period,
   input  logic [LVL_W-1:0] pit_level,
   input  logic             pit_ack,
   input  logic [LVL_W-1:0] irq_mask,
   output logic             wd_rst_pulse,
   output logic             wd_irq,
   output logic             pit_irq,
   output logic [LVL_W-1:0] pit_irq_lvl,
   output logic             wake_req,
   output logic             busmon_en,
   output logic             dblflt_en,
   output logic             spur_en
);

   gate_s gate;

   tmr_gate_ctl #(.STOP_HOLDS_WD(STOP_HOLDS_WD)) ctl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .lpstop_req (lpstop_req),
      .stop_in    (stop_in),
      .halt_in    (halt_in),
      .freeze_in  (freeze_in),
      .cfg_frz_wd (cfg_frz_wd),
      .cfg_frz_pit(cfg_frz_pit),
      .wd_en      (wd_en),
      .gate       (gate),
      .busmon_en  (busmon_en),
      .dblflt_en  (dblflt_en),
      .spur_en    (spur_en)
   );

   tmr_wdog #(.WD_W(WD_W), .WD_LIMIT(WD_LIMIT), .KEY_W(8)) wdog_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (wd_en),
      .run       (gate.wd_run),
      .mode      (wd_irq_mode),
      .svc_wr    (svc_wr),
      .svc_data  (svc_data),
      .rst_pulse (wd_rst_pulse),
      .irq       (wd_irq)
   );

   tmr_pit #(.PIT_W(PIT_W), .LVL_W(LVL_W)) pit_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .hold    (gate.pit_hold),
      .period  (pit_period),
      .level   (pit_level),
      .ack     (pit_ack),
      .irq     (pit_irq),
      .irq_lvl (pit_irq_lvl)
   );

   logic wake_d;
   assign wake_d = gate.lp_active && pit_irq && (pit_level > irq_mask);

   generate
      if (SYNC_WAKE) begin : g_wake_reg
         logic wake_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) wake_q <= 1'b0;
            else        wake_q <= wake_d;
         end
         assign wake_req = wake_q;
      end else begin : g_wake_comb
         assign wake_req = wake_d;
      end
   endgenerate

endmodule

// File: rtl/tmr_gate_chk.sv
module tmr_gate_chk #(
   parameter int unsigned PIT_W     = 8,
   parameter int unsigned LVL_W     = 3,
   parameter bit          SYNC_WAKE = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             halt_in,
   input logic             wd_irq_mode,
   input logic             svc_wr,
   input logic [PIT_W-1:0] pit_period,
   input logic             pit_ack,
   input logic [LVL_W-1:0] irq_mask,
   input logic             wd_rst_pulse,
   input logic             wd_irq,
   input logic             pit_irq,
   input logic [LVL_W-1:0] pit_irq_lvl,
   input logic             wake_req,
   input logic             busmon_en,
   input logic             dblflt_en,
   input logic             spur_en
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |-> (!wd_rst_pulse && !wd_irq && !pit_irq && !wake_req));

   // R2
   wd_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_rst_pulse |=> !wd_rst_pulse);

   // R2
   wd_pulse_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_rst_pulse) |-> !$past(wd_irq_mode));

   // R2
   wd_irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_irq && !svc_wr) |=> wd_irq);

   // R6
   halt_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_in && busmon_en) |=> busmon_en);

   // R7
   monitors_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busmon_en == dblflt_en) && (dblflt_en == spur_en));

   // R9
   pit_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pit_irq && !pit_ack) |=> pit_irq);

   // R9
   pit_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pit_irq |-> (pit_irq_lvl == '0));

   // R10
   pit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pit_period == '0 && !pit_irq) |=> !pit_irq);

   generate
      if (!SYNC_WAKE) begin : g_wake
         // R11
         wake_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wake_req |-> (pit_irq && !busmon_en && pit_irq_lvl > irq_mask));
      end
   endgenerate

endmodule

bind tmr_gate_top tmr_gate_chk #(
   .PIT_W(PIT_W), .LVL_W(LVL_W), .SYNC_WAKE(SYNC_WAKE)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .halt_in      (halt_in),
   .wd_irq_mode  (wd_irq_mode),
   .svc_wr       (svc_wr),
   .pit_period   (pit_period),
   .pit_ack      (pit_ack),
   .irq_mask     (irq_mask),
   .wd_rst_pulse (wd_rst_pulse),
   .wd_irq       (wd_irq),
   .pit_irq      (pit_irq),
   .pit_irq_lvl  (pit_irq_lvl),
   .wake_req     (wake_req),
   .busmon_en    (busmon_en),
   .dblflt_en    (dblflt_en),
   .spur_en      (spur_en)
);

// File: tb/tmr_gate_tb.sv
`timescale 1ns/1ps
module tmr_gate_top_tb_top;

   localparam int PW = 8;
   localparam int LW = 3;
   localparam int LIM = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic lpstop_req, stop_in, halt_in, freeze_in, cfg_frz_wd, cfg_frz_pit;
   logic wd_en, wd_irq_mode, svc_wr, pit_ack;
   logic [7:0]    svc_data;
   logic [PW-1:0] pit_period;
   logic [LW-1:0] pit_level, irq_mask, pit_irq_lvl;
   logic wd_rst_pulse, wd_irq, pit_irq, wake_req, busmon_en, dblflt_en, spur_en;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   tmr_gate_top #(.WD_W(8), .WD_LIMIT(LIM), .PIT_W(PW), .LVL_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .lpstop_req(lpstop_req), .stop_in(stop_in),
      .halt_in(halt_in), .freeze_in(freeze_in), .cfg_frz_wd(cfg_frz_wd),
      .cfg_frz_pit(cfg_frz_pit), .wd_en(wd_en), .wd_irq_mode(wd_irq_mode),
      .svc_wr(svc_wr), .svc_data(svc_data), .pit_period(pit_period),
      .pit_level(pit_level), .pit_ack(pit_ack), .irq_mask(irq_mask),
      .wd_rst_pulse(wd_rst_pulse), .wd_irq(wd_irq), .pit_irq(pit_irq),
      .pit_irq_lvl(pit_irq_lvl), .wake_req(wake_req), .busmon_en(busmon_en),
      .dblflt_en(dblflt_en), .spur_en(spur_en)
   );

   // {lpstop_req, halt_in, freeze_in, expected monitor enable}
   localparam logic [3:0] GATE_VEC [0:5] = '{
      4'b0001, 4'b1000, 4'b1101, 4'b0011, 4'b1010, 4'b0111
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic pick(input int sel);
      case (sel)
         0:       return wd_rst_pulse;
         1:       return wd_irq;
         default: return pit_irq;
      endcase
   endfunction

   task automatic meas(input int sel, output int n);
      n = 0;
      do begin
         step(1);
         n++;
      end while (!pick(sel) && n < 200);
   endtask

   task automatic svc(input logic [7:0] d);
      svc_wr = 1'b1;
      svc_data = d;
      step(1);
      svc_wr = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      lpstop_req = 0; stop_in = 0; halt_in = 0; freeze_in = 0;
      cfg_frz_wd = 0; cfg_frz_pit = 0; wd_en = 0; wd_irq_mode = 0;
      svc_wr = 0; svc_data = 0; pit_period = 0; pit_level = 0;
      pit_ack = 0; irq_mask = 0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int n;
      #1 rst_n = 1'b0;
      do_reset();

      // R1 reset state
      chk("R1 pulse", wd_rst_pulse, 0);
      chk("R1 wd_irq", wd_irq, 0);
      chk("R1 pit_irq", pit_irq, 0);
      chk("R1 lvl", pit_irq_lvl, 0);
      chk("R1 wake", wake_req, 0);
      chk("R1 busmon", busmon_en, 1);

      // R7 R6 table of gating vectors
      for (int i = 0; i < 6; i++) begin
         lpstop_req = 1'b0; halt_in = 1'b0; freeze_in = 1'b0;
         step(1);
         lpstop_req = GATE_VEC[i][3];
         halt_in    = GATE_VEC[i][2];
         freeze_in  = GATE_VEC[i][1];
         step(2);
         chk($sformatf("R7 vec%0d busmon", i), busmon_en, GATE_VEC[i][0]);
         chk($sformatf("R7 vec%0d dblflt", i), dblflt_en, GATE_VEC[i][0]);
         chk($sformatf("R7 vec%0d spur", i), spur_en, GATE_VEC[i][0]);
      end

      // R2 reset-mode expiry
      do_reset();
      wd_en = 1;
      meas(0, n);
      chk("R2 expiry edge", n, LIM + 1);
      step(1);
      chk("R2 pulse width", wd_rst_pulse, 0);

      // R4 ordinary stop
      do_reset();
      stop_in = 1; wd_en = 1;
      meas(0, n);
      chk("R4 stop expiry edge", n, LIM + 1);

      // R3 correct service
      do_reset();
      wd_en = 1;
      step(10);
      svc(8'h55); svc(8'hAA);
      meas(0, n);
      chk("R3 after service", n, LIM + 1);

      // R3 reversed keys
      do_reset();
      wd_en = 1;
      step(5);
      svc(8'hAA); svc(8'h55);
      meas(0, n);
      chk("R3 reversed keys", n, LIM + 1 - 7);

      // R3 stray write between keys
      do_reset();
      wd_en = 1;
      step(3);
      svc(8'h55); svc(8'h12); svc(8'hAA);
      meas(0, n);
      chk("R3 stray write", n, LIM + 1 - 6);

      // R5 low-power stop freezes the watchdog
      do_reset();
      wd_en = 1;
      step(5);
      lpstop_req = 1;
      step(21);
      chk("R5 pulse held", wd_rst_pulse, 0);
      chk("R7 busmon in lp", busmon_en, 0);
      lpstop_req = 0;
      step(1);
      meas(0, n);
      chk("R5 resume", n, LIM + 1 - 6);

      // R8 freeze with watchdog bit
      do_reset();
      cfg_frz_wd = 1; wd_en = 1;
      step(5);
      freeze_in = 1;
      step(20);
      chk("R7 dblflt in freeze", dblflt_en, 1);
      chk("R7 spur in freeze", spur_en, 1);
      freeze_in = 0;
      meas(0, n);
      chk("R8 wd freeze", n, LIM + 1 - 5);

      // R8 freeze without watchdog bit
      do_reset();
      cfg_frz_pit = 1; freeze_in = 1; wd_en = 1;
      meas(0, n);
      chk("R8 wd bit clear", n, LIM + 1);

      // R2 interrupt mode
      do_reset();
      wd_irq_mode = 1; wd_en = 1;
      meas(1, n);
      chk("R2 irq edge", n, LIM + 1);
      chk("R2 no pulse in irq mode", wd_rst_pulse, 0);
      step(3);
      chk("R2 irq sticky", wd_irq, 1);
      svc(8'h55); svc(8'hAA);
      chk("R2 irq cleared", wd_irq, 0);

      // R1 outputs low while reset held
      do_reset();
      wd_irq_mode = 1; wd_en = 1;
      meas(1, n);
      rst_n = 1'b0;
      #1;
      chk("R1 irq in reset", wd_irq, 0);

      // R6 halt defers entry, ignored once inside
      do_reset();
      halt_in = 1; lpstop_req = 1;
      step(5);
      chk("R6 deferred", busmon_en, 1);
      halt_in = 0;
      step(1);
      chk("R6 entered", busmon_en, 0);
      halt_in = 1;
      step(2);
      chk("R6 halt inside", busmon_en, 0);
      lpstop_req = 0;
      step(1);
      chk("R5 exit", busmon_en, 1);

      // R9 periodic timer
      do_reset();
      pit_period = 4; pit_level = 5;
      meas(2, n);
      chk("R9 first", n, 5);
      chk("R9 level", pit_irq_lvl, 5);
      pit_ack = 1;
      step(1);
      pit_ack = 0;
      chk("R9 ack", pit_irq, 0);
      chk("R9 level idle", pit_irq_lvl, 0);
      meas(2, n);
      chk("R9 repeat", n, 3);

      // R10 zero period
      pit_ack = 1; pit_period = 0;
      step(1);
      pit_ack = 0;
      step(30);
      chk("R10 stopped", pit_irq, 0);

      // R11 runs in low-power stop and wakes
      do_reset();
      lpstop_req = 1; irq_mask = 3; pit_period = 4; pit_level = 5;
      meas(2, n);
      chk("R11 pit in lp", n, 5);
      chk("R11 wake", wake_req, 1);
      irq_mask = 6;
      step(1);
      chk("R11 masked", wake_req, 0);
      irq_mask = 3; lpstop_req = 0;
      step(1);
      chk("R11 not in lp", wake_req, 0);

      // R8 freeze with timer bit
      do_reset();
      cfg_frz_pit = 1; freeze_in = 1; pit_period = 4;
      step(20);
      chk("R8 pit frozen", pit_irq, 0);
      freeze_in = 0;
      meas(2, n);
      chk("R8 pit resume", n, 5);

      do_reset();
      cfg_frz_wd = 1; freeze_in = 1; pit_period = 4;
      meas(2, n);
      chk("R8 pit bit clear", n, 5);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule